// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block scans a panel raster for a TFT or passive LCD. It produces horizontal sync, vertical sync, data-enable, a pixel clock and a one-cycle pixel clock enable, plus an AC-bias output for passive panels. A pixel clock divider derives every pixel period from the logic clock. Three packed 32-bit timing words and a control pair (scan enable, TFT select) configure it. The decoded timing is latched when a frame starts, so writes to the timing words take effect at a frame boundary.

The block also keeps three status flags:
- A frame-done flag. Clearing enable never cuts a frame short. The frame in progress completes, the scan stops and frame-done is raised.
- A sticky underflow flag. It records an active pixel slot in which the pixel source had no valid data.
- A sticky sync-lost flag, set by an external error pulse.

The control FSM has four states: `ST_IDLE` (after reset, no scan), `ST_RUN` (scanning with enable high), `ST_DRAIN` (enable dropped, finishing the current frame) and `ST_DONE` (scan stopped after a drained frame). Its transitions are:
- IDLE to RUN, and DONE to RUN, on enable. This is the start transition.
- RUN to DRAIN when enable falls before the end of a frame.
- RUN to DONE when enable is already low at the frame end.
- DRAIN back to RUN when enable returns.
- DRAIN to DONE at the frame end.
- RUN stays in RUN at a frame end while enable is high.

Top module: `lcd_raster_timing`

## Requirements
- R1: Horizontal word: bits 9:0 = active pixels-1, 15:10 = hsync width-1, 23:16 = front porch-1, 31:24 = back porch-1. Each line is, in pixel clocks, sync, then back porch, then active, then front porch. Hsync is asserted during the sync part of every line.
- R2: Vertical word: bits 9:0 = active lines-1, 15:10 = vsync width-1. Bits 23:16 give the front porch lines and bits 31:24 the back porch lines, both taken as-is with no minus-one. The frame order is sync, back porch, active, front porch. Data-enable is asserted only in active pixels of active lines.
- R3: Divider field bits 7:0 of the third word. The effective divider is the field clamped to at least 2 for TFT and at least 3 for passive panels (8 bits caps it at 255). The pixel clock enable pulses once every effective-divider logic clock cycles.
- R4: The pixel clock output (before polarity) is high for the last D - floor(D/2) cycles of each D-cycle pixel period and low for the rest.
- R5: Polarity bits of the third word act immediately: bit 20 inverts hsync, bit 21 vsync, bit 22 the pixel clock, bit 23 data-enable, bit 24 AC-bias.
- R6: After reset, and while no scan is running, hsync, vsync, data-enable, pixel clock and pixel clock enable are at their inactive (uninverted 0) level, and all three flags are 0.
- R7: Enable sampled high for one edge starts a scan. Frame-done rises exactly Htotal*Vtotal*D clock edges after that start edge, where D is the effective divider.
- R8: Frame-done stays set while enable is low. It clears at the first edge that samples enable high.
- R9: While enable stays high, frames follow back to back with no gap and frame-done stays 0.
- R10: On passive panels AC-bias toggles at every (N+1)-th line end, with N = bits 15:8 of the third word. On TFT panels it does not change.
- R11: The underflow flag is set when a pixel clock enable falls inside the data-enable window while pixel valid is low. It is sticky while enabled and is cleared while enable is low.
- R12: The sync-lost flag is set by a sync error pulse during a scan. It is sticky while enabled and is cleared while enable is low.
- R13: Timing words written during a frame do not alter that frame. They are used from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en_i | input | 1 | Scan enable |
| ctrl_tft_i | input | 1 | 1 = TFT panel, 0 = passive panel |
| htiming_i | input | 32 | Horizontal timing word |
| vtiming_i | input | 32 | Vertical timing word |
| ctiming_i | input | 32 | Divider, AC-bias count and polarity word |
| pix_valid_i | input | 1 | Pixel source has data for the current slot |
| sync_err_i | input | 1 | Sync error pulse from the pixel path |
| pclk_en_o | output | 1 | One-cycle pixel clock enable |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| acb_o | output | 1 | AC-bias drive |
| frame_done_o | output | 1 | Scan stopped after the drained frame |
| underflow_o | output | 1 | Sticky pixel underflow flag |
| sync_lost_o | output | 1 | Sticky sync-lost flag |

## Verification
The main function is swept over two raster geometries, six divider fields that span both clamp floors, both panel types, both polarity settings and three AC-bias counts. Counting cycles of each output over one drained frame separates the minus-one fields from the direct ones and the sync, active and porch ordering. The same counts also catch the clamp floor for each panel type and the pixel clock duty. Separate patterns cover the rest:
- Enable held high over two frames tells back-to-back scanning apart from a stop-start.
- A mid-frame rewrite of the timing words tells frame-boundary latching from live use.
- Valid-data and starved pixel sources tell the underflow condition apart.
- A maximum divider is measured pulse to pulse.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    // field widths of the packed timing words
    localparam int PPL_W = 10;
    localparam int HSW_W = 6;
    localparam int HP_W  = 8;
    localparam int LPP_W = 10;
    localparam int VSW_W = 6;
    localparam int VP_W  = 8;
    localparam int DIV_W = 8;
    localparam int ACB_W = 8;
    localparam int POL_W = 6;

    // counter widths derived from the largest raster the fields allow
    localparam int HCNT_W = $clog2((2**PPL_W) + (2**HSW_W) + 2 * (2**HP_W));
    localparam int VCNT_W = $clog2((2**LPP_W) + (2**VSW_W) + 2 * (2**VP_W));

    // polarity bit positions inside the polarity field
    localparam int POL_HS   = 0;
    localparam int POL_VS   = 1;
    localparam int POL_PCLK = 2;
    localparam int POL_DE   = 3;
    localparam int POL_ACB  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } scan_state_t;

    // decoded raster, held as boundaries so the scan needs only compares
    typedef struct packed {
        logic [HCNT_W-1:0] h_sync_end;
        logic [HCNT_W-1:0] h_act_start;
        logic [HCNT_W-1:0] h_act_end;
        logic [HCNT_W-1:0] h_total;
        logic [VCNT_W-1:0] v_sync_end;
        logic [VCNT_W-1:0] v_act_start;
        logic [VCNT_W-1:0] v_act_end;
        logic [VCNT_W-1:0] v_total;
        logic [DIV_W-1:0]  div;
        logic [ACB_W-1:0]  acb;
        logic              tft;
    } raster_cfg_t;

    function automatic raster_cfg_t decode_cfg(
        input logic [31:0]      hw,
        input logic [31:0]      vw,
        input logic [DIV_W-1:0] div_f,
        input logic [ACB_W-1:0] acb_f,
        input logic             tft
    );
        raster_cfg_t c;
        logic [HCNT_W-1:0] h_sw, h_bp, h_ac, h_fp;
        logic [VCNT_W-1:0] v_sw, v_bp, v_ac, v_fp;
        // horizontal fields all carry a minus-one offset
        h_ac = HCNT_W'(hw[9:0])   + 1'b1;
        h_sw = HCNT_W'(hw[15:10]) + 1'b1;
        h_fp = HCNT_W'(hw[23:16]) + 1'b1;
        h_bp = HCNT_W'(hw[31:24]) + 1'b1;
        // vertical porches are taken directly
        v_ac = VCNT_W'(vw[9:0])   + 1'b1;
        v_sw = VCNT_W'(vw[15:10]) + 1'b1;
        v_fp = VCNT_W'(vw[23:16]);
        v_bp = VCNT_W'(vw[31:24]);
        c.h_sync_end  = h_sw;
        c.h_act_start = h_sw + h_bp;
        c.h_act_end   = h_sw + h_bp + h_ac;
        c.h_total     = h_sw + h_bp + h_ac + h_fp;
        c.v_sync_end  = v_sw;
        c.v_act_start = v_sw + v_bp;
        c.v_act_end   = v_sw + v_bp + v_ac;
        c.v_total     = v_sw + v_bp + v_ac + v_fp;
        c.div         = div_f;
        c.acb         = acb_f;
        c.tft         = tft;
        return c;
    endfunction

endpackage

// File: rtl/lrt_ctrl.sv
module lrt_ctrl
    import lrt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic frame_end,
    output logic start,
    output logic load,
    output logic run,
    output logic done
);

    scan_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = ST_RUN;
            ST_DONE:  if (en) state_d = ST_RUN;
            ST_RUN: begin
                if (frame_end) begin
                    state_d = en ? ST_RUN : ST_DONE;
                end else if (!en) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (en) begin
                    state_d = ST_RUN;
                end else if (frame_end) begin
                    state_d = ST_DONE;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run   = 1'b0;
        done  = 1'b0;
        start = 1'b0;
        unique case (state_q)
            ST_IDLE:  start = en;
            ST_DONE: begin
                done  = 1'b1;
                start = en;
            end
            ST_RUN:   run = 1'b1;
            ST_DRAIN: run = 1'b1;
            default:  ;
        endcase
        load = start || (run && frame_end && en);
    end

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !en) |=> done);

    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en) |=> !done);

    a_r7_drain_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && frame_end && !en) |=> done);

    a_r9_no_done_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en) |=> !done);

endmodule

// File: rtl/lrt_pclk_div.sv
module lrt_pclk_div #(
    parameter int DIV_W   = 8,
    parameter int MIN_TFT = 2,
    parameter int MIN_STN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_field,
    input  logic             tft,
    output logic             tick,
    output logic             pclk_raw
);

    logic [DIV_W-1:0] floor_v;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] last_v;
    logic [DIV_W-1:0] cnt_q;

    always_comb begin
        floor_v = tft ? DIV_W'(MIN_TFT) : DIV_W'(MIN_STN);
        div_eff = (div_field < floor_v) ? floor_v : div_field;
        last_v  = div_eff - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == last_v) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick     = run && (cnt_q == last_v);
    assign pclk_raw = run && (cnt_q >= (div_eff >> 1));

    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r4_pclk_low_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !pclk_raw);

endmodule

// File: rtl/lrt_scan.sv
module lrt_scan
    import lrt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        restart,
    input  logic        tick,
    input  raster_cfg_t cfg,
    output logic        frame_end,
    output logic        hsync_raw,
    output logic        vsync_raw,
    output logic        de_raw,
    output logic        acb_raw
);

    logic [HCNT_W-1:0] hcnt_q;
    logic [VCNT_W-1:0] vcnt_q;
    logic [ACB_W-1:0]  lcnt_q;
    logic              acb_q;
    logic              line_end;
    logic [DIV_W-1:0]  div_unused;

    assign div_unused = cfg.div;

    assign line_end  = tick && (hcnt_q == cfg.h_total - 1'b1);
    assign frame_end = line_end && (vcnt_q == cfg.v_total - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
        end else if (restart) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
        end else if (tick) begin
            if (line_end) begin
                hcnt_q <= '0;
                vcnt_q <= frame_end ? '0 : vcnt_q + 1'b1;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    // AC-bias line counter, passive panels only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcnt_q <= '0;
            acb_q  <= 1'b0;
        end else if (restart) begin
            lcnt_q <= '0;
        end else if (line_end && !cfg.tft) begin
            if (lcnt_q == cfg.acb) begin
                lcnt_q <= '0;
                acb_q  <= ~acb_q;
            end else begin
                lcnt_q <= lcnt_q + 1'b1;
            end
        end
    end

    assign hsync_raw = run && (hcnt_q < cfg.h_sync_end);
    assign vsync_raw = run && (vcnt_q < cfg.v_sync_end);
    assign de_raw    = run
                     && (hcnt_q >= cfg.h_act_start) && (hcnt_q < cfg.h_act_end)
                     && (vcnt_q >= cfg.v_act_start) && (vcnt_q < cfg.v_act_end);
    assign acb_raw   = acb_q;

    a_r1_de_outside_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> !hsync_raw);

    a_r2_de_outside_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> !vsync_raw);

    a_r10_acb_fixed_on_tft: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.tft && !restart) |=> $stable(acb_raw));

endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
    import lrt_pkg::*;
#(
    parameter int MIN_DIV_TFT = 2,
    parameter int MIN_DIV_STN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_en_i,
    input  logic        ctrl_tft_i,
    input  logic [31:0] htiming_i,
    input  logic [31:0] vtiming_i,
    input  logic [31:0] ctiming_i,
    input  logic        pix_valid_i,
    input  logic        sync_err_i,
    output logic        pclk_en_o,
    output logic        pclk_o,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        de_o,
    output logic        acb_o,
    output logic        frame_done_o,
    output logic        underflow_o,
    output logic        sync_lost_o
);

    raster_cfg_t      cfg_q;
    logic             start, load, run, done;
    logic             tick, pclk_raw, frame_end;
    logic             hsync_raw, vsync_raw, de_raw, acb_raw;
    logic [POL_W-1:0] pol;
    logic             uf_q, sl_q;
    logic             ctl_unused;

    assign pol        = ctiming_i[25:20];
    assign ctl_unused = ^{ctiming_i[31:26], ctiming_i[19:16], pol[POL_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= decode_cfg(htiming_i, vtiming_i, ctiming_i[7:0],
                                ctiming_i[15:8], ctrl_tft_i);
        end
    end

    lrt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_en_i),
        .frame_end (frame_end),
        .start     (start),
        .load      (load),
        .run       (run),
        .done      (done)
    );

    lrt_pclk_div #(
        .DIV_W   (DIV_W),
        .MIN_TFT (MIN_DIV_TFT),
        .MIN_STN (MIN_DIV_STN)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div_field (cfg_q.div),
        .tft       (cfg_q.tft),
        .tick      (tick),
        .pclk_raw  (pclk_raw)
    );

    lrt_scan u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (start),
        .tick      (tick),
        .cfg       (cfg_q),
        .frame_end (frame_end),
        .hsync_raw (hsync_raw),
        .vsync_raw (vsync_raw),
        .de_raw    (de_raw),
        .acb_raw   (acb_raw)
    );

    // sticky error flags, wiped while the controller is disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uf_q <= 1'b0;
            sl_q <= 1'b0;
        end else if (!ctrl_en_i) begin
            uf_q <= 1'b0;
            sl_q <= 1'b0;
        end else begin
            if (tick && de_raw && !pix_valid_i) uf_q <= 1'b1;
            if (sync_err_i && run)              sl_q <= 1'b1;
        end
    end

    assign pclk_en_o    = tick;
    assign pclk_o       = pclk_raw  ^ pol[POL_PCLK];
    assign hsync_o      = hsync_raw ^ pol[POL_HS];
    assign vsync_o      = vsync_raw ^ pol[POL_VS];
    assign de_o         = de_raw    ^ pol[POL_DE];
    assign acb_o        = acb_raw   ^ pol[POL_ACB];
    assign frame_done_o = done;
    assign underflow_o  = uf_q;
    assign sync_lost_o  = sl_q;

    a_r11_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en_i |=> (!underflow_o && !sync_lost_o));

    a_r11_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && ctrl_en_i) |=> underflow_o);

    a_r12_sync_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lost_o && ctrl_en_i) |=> sync_lost_o);

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pclk_en_o && !de_raw && !hsync_raw && !vsync_raw));

endmodule

// File: tb/lcd_raster_timing_tb_top.sv
module lcd_raster_timing_tb_top;

    localparam int CLK_HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        tft = 1'b0;
    logic        pix_valid = 1'b1;
    logic        sync_err = 1'b0;
    logic [31:0] hword = '0;
    logic [31:0] vword = '0;
    logic [31:0] cword = '0;
    logic        pclk_en, pclk, hs, vs, de, acb, done, uf, sl;

    int checks = 0;
    int errors = 0;

    always #CLK_HALF clk = ~clk;

    lcd_raster_timing dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_en_i    (en),
        .ctrl_tft_i   (tft),
        .htiming_i    (hword),
        .vtiming_i    (vword),
        .ctiming_i    (cword),
        .pix_valid_i  (pix_valid),
        .sync_err_i   (sync_err),
        .pclk_en_o    (pclk_en),
        .pclk_o       (pclk),
        .hsync_o      (hs),
        .vsync_o      (vs),
        .de_o         (de),
        .acb_o        (acb),
        .frame_done_o (done),
        .underflow_o  (uf),
        .sync_lost_o  (sl)
    );

    // geometry sets: A and B
    int g_ppl[2] = '{4, 6};
    int g_hsw[2] = '{1, 2};
    int g_hfp[2] = '{1, 3};
    int g_hbp[2] = '{2, 1};
    int g_lpp[2] = '{3, 4};
    int g_vsw[2] = '{1, 2};
    int g_vfp[2] = '{1, 0};
    int g_vbp[2] = '{0, 2};
    int div_list[6] = '{0, 1, 2, 3, 4, 7};
    int acb_list[3] = '{0, 1, 2};

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_h(input int s);
        return {8'(g_hbp[s] - 1), 8'(g_hfp[s] - 1), 6'(g_hsw[s] - 1), 10'(g_ppl[s] - 1)};
    endfunction

    function automatic logic [31:0] mk_v(input int s);
        return {8'(g_vbp[s]), 8'(g_vfp[s]), 6'(g_vsw[s] - 1), 10'(g_lpp[s] - 1)};
    endfunction

    function automatic logic [31:0] mk_c(input int divf, input int acbf, input int pol);
        return {6'd0, 6'(pol), 4'd0, 8'(acbf), 8'(divf)};
    endfunction

    function automatic int eff_div(input int f, input bit t);
        int m;
        m = t ? 2 : 3;
        return (f < m) ? m : f;
    endfunction

    function automatic int htot(input int s);
        return g_ppl[s] + g_hsw[s] + g_hfp[s] + g_hbp[s];
    endfunction

    function automatic int vtot(input int s);
        return g_lpp[s] + g_vsw[s] + g_vfp[s] + g_vbp[s];
    endfunction

    task automatic wait_done();
        for (int i = 0; i < 100000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        check_eq("R7 scan reaches frame done", int'(done), 1);
    endtask

    // one drained frame, every output counted over it
    task automatic one_frame(input int s, input int divf, input int pol,
                             input int acbf, input bit t);
        int d, n, ncyc, ntk, nhs, nvs, npc, nde, ntg;
        logic prev;
        d = eff_div(divf, t);
        n = htot(s) * vtot(s) * d;
        ncyc = 0; ntk = 0; nhs = 0; nvs = 0; npc = 0; nde = 0; ntg = 0;
        @(negedge clk);
        hword = mk_h(s);
        vword = mk_v(s);
        cword = mk_c(divf, acbf, pol);
        tft   = t;
        @(negedge clk);
        prev = acb;
        en = 1'b1;
        forever begin
            @(posedge clk);
            @(negedge clk);
            en = 1'b0;
            if (done || ncyc > n + 10) break;
            ncyc++;
            if (pclk_en) ntk++;
            if (hs ^ pol[0]) nhs++;
            if (vs ^ pol[1]) nvs++;
            if (pclk ^ pol[2]) npc++;
            if (de ^ pol[3]) nde++;
            if (acb != prev) ntg++;
            prev = acb;
        end
        check_eq("R7 frame length in cycles", ncyc, n);
        check_eq("R7 frame done after drain", int'(done), 1);
        check_eq("R3 pixel enables per frame", ntk, htot(s) * vtot(s));
        check_eq("R1 R2 R5 data-enable cycles", nde, g_ppl[s] * g_lpp[s] * d);
        check_eq("R1 R5 hsync cycles", nhs, g_hsw[s] * vtot(s) * d);
        check_eq("R2 R5 vsync cycles", nvs, g_vsw[s] * htot(s) * d);
        check_eq("R4 R5 pixel clock high cycles", npc, (d - d / 2) * htot(s) * vtot(s));
        check_eq("R10 AC-bias toggles", ntg, t ? 0 : (vtot(s) - 1) / (acbf + 1));
    endtask

    initial begin
        int ncnt, gap, nA;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        check_eq("R6 hsync idle", int'(hs), 0);
        check_eq("R6 vsync idle", int'(vs), 0);
        check_eq("R6 de idle", int'(de), 0);
        check_eq("R6 pclk idle", int'(pclk), 0);
        check_eq("R6 pclk enable idle", int'(pclk_en), 0);
        check_eq("R6 flags idle", int'({done, uf, sl}), 0);

        // R5 polarity applies while idle
        cword = mk_c(2, 0, 6'h0F);
        @(negedge clk);
        check_eq("R5 R6 idle inverted outputs", int'({hs, vs, pclk, de}), 4'hF);
        cword = '0;

        // main sweep
        for (int s = 0; s < 2; s++) begin
            for (int t = 0; t < 2; t++) begin
                for (int di = 0; di < 6; di++) begin
                    one_frame(s, div_list[di], ((s + t + di) % 2 == 1) ? 6'h1F : 6'h00,
                              acb_list[di % 3], t[0]);
                end
            end
        end

        // R8 done held while disabled, cleared by enable
        repeat (20) @(negedge clk);
        check_eq("R8 done held while disabled", int'(done), 1);
        en = 1'b1;
        @(negedge clk);
        check_eq("R8 done cleared by enable", int'(done), 0);
        en = 1'b0;
        wait_done();

        // R9 back-to-back frames, geometry A, TFT, divider 2
        @(negedge clk);
        hword = mk_h(0); vword = mk_v(0); cword = mk_c(2, 0, 0); tft = 1'b1;
        en = 1'b1;
        ncnt = 0; seen = 1'b0;
        for (int i = 0; i < 2 * htot(0) * vtot(0) * 2; i++) begin
            @(negedge clk);
            if (pclk_en) ncnt++;
            if (done) seen = 1'b1;
        end
        check_eq("R9 enables over two frames", ncnt, 2 * htot(0) * vtot(0));
        check_eq("R9 no done while enabled", int'(seen), 0);

        // R11 underflow
        check_eq("R11 no underflow with valid data", int'(uf), 0);
        pix_valid = 1'b0;
        repeat (htot(0) * vtot(0) * 2) @(negedge clk);
        check_eq("R11 underflow set on starved pixel", int'(uf), 1);
        repeat (3) @(negedge clk);
        check_eq("R11 underflow sticky", int'(uf), 1);
        en = 1'b0;
        @(negedge clk);
        check_eq("R11 underflow cleared by disable", int'(uf), 0);
        pix_valid = 1'b1;
        wait_done();

        // R12 sync lost
        en = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R12 sync lost clear before error", int'(sl), 0);
        sync_err = 1'b1;
        @(negedge clk);
        sync_err = 1'b0;
        check_eq("R12 sync lost set", int'(sl), 1);
        repeat (5) @(negedge clk);
        check_eq("R12 sync lost sticky", int'(sl), 1);
        en = 1'b0;
        @(negedge clk);
        check_eq("R12 sync lost cleared by disable", int'(sl), 0);
        wait_done();

        // R13 mid-frame rewrite does not touch current frame
        nA = htot(0) * vtot(0) * 2;
        hword = mk_h(0); vword = mk_v(0); cword = mk_c(2, 0, 0); tft = 1'b1;
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        ncnt = 1;
        hword = mk_h(1); vword = mk_v(1); cword = mk_c(7, 0, 0);
        for (int i = 0; i < 100000; i++) begin
            @(negedge clk);
            if (done) break;
            ncnt++;
        end
        check_eq("R13 frame keeps latched timing", ncnt, nA);

        // R3 maximum divider, passive panel
        hword = mk_h(0); vword = mk_v(0); cword = mk_c(255, 0, 0); tft = 1'b0;
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            if (pclk_en) break;
            @(negedge clk);
        end
        gap = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            gap++;
            if (pclk_en) break;
        end
        check_eq("R3 enable period at divider 255", gap, 255);
        wait_done();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 2 * CLK_HALF);
        checks++;
        errors++;
        $display("FAIL watchdog R7 actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule